// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns an addressing-mode code plus the register and immediate operands of a load into the memory address that the load will use. Six addressing styles are supported: a literal address, a register used as a pointer, a register plus a signed offset, the sum of two registers, a pointer read from memory, and a pointer register that steps by one word on every use (after use when stepping up, before use when stepping down).

The calling pipeline presents a mode and operands with a one-cycle `start` pulse. Every mode except memory-indirect returns its address one cycle later. Memory-indirect issues one read to a word memory at the base register value and waits for that memory's ready signal. The word that comes back is the address. While that fetch is in flight the block reports `busy` and ignores new requests. For the two stepping modes the block also hands back the updated base register value with a one-cycle write enable, so that the register file can store it.

Top module: `eff_addr_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `ea_valid`, `wb_en`, `mem_req` and `busy` are all 0.
- R2: Mode code 0 (absolute): `ea` equals `imm`.
- R3: Mode code 1 (register pointer): `ea` equals `base`.
- R4: Mode code 2 (base plus offset): `ea` equals `base + imm`, wrapping modulo 2^32.
- R5: Mode code 3 (base plus index): `ea` equals `base + index`, wrapping modulo 2^32.
- R6: Mode code 4 (memory-indirect): from the cycle after `start`, `mem_req` is 1 and `mem_addr` holds the `base` value until the edge at which `mem_ready` is 1. In the following cycle `ea_valid` is 1 and `ea` equals the `mem_rdata` value sampled at that edge.
- R7: While a memory-indirect fetch is pending, `busy` is 1 and `ea_valid` stays 0. A `start` seen during that time is ignored: it produces no result and does not change `ea`.
- R8: Mode code 5 (step up after use): `ea` equals `base`, and `wb_data` equals `base + STEP` (default 4), wrapping.
- R9: Mode code 6 (step down before use): `ea` and `wb_data` both equal `base - STEP`, wrapping below zero.
- R10: `wb_en` is 1 only in the `ea_valid` cycle of a mode 5 or mode 6 request, and is 0 for every other mode.
- R11: Mode code 7 is reserved and is handled exactly like absolute mode.
- R12: For every mode other than 4, `ea_valid` is 1 in the single cycle after the edge that sampled `start`, and 0 in the cycle after that unless a new request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted when `busy` is 0 |
| mode | input | 3 | Addressing-mode code (0..7) |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| imm | input | 32 | Immediate address or offset |
| mem_req | output | 1 | Indirect pointer read request |
| mem_addr | output | 32 | Address of the pointer word |
| mem_ready | input | 1 | Memory has the pointer word on `mem_rdata` |
| mem_rdata | input | 32 | Pointer word from memory |
| busy | output | 1 | Indirect fetch in flight; requests ignored |
| ea_valid | output | 1 | One-cycle pulse: `ea` is new |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | One-cycle write enable for the base register |
| wb_data | output | 32 | Updated base register value |

## Verification
The assertions assume that `mem_ready` is only meaningful while `mem_req` is high, and that `mem_rdata` is stable at the edge where `mem_ready` is sampled. The bench's memory model therefore drives `mem_rdata` combinationally from `mem_addr`, and raises `mem_ready` only during a pending fetch, after a chosen number of wait cycles. All stimulus changes on the falling edge. `start` is pulsed for one cycle and is raised during a fetch only in the test that checks requests are ignored while busy.

// File: rtl/eag_pkg.sv
// Package: shared mode encoding for the effective address generator.
// Assumes the mode field is three bits wide; code 7 is reserved.
package eag_pkg;
    typedef enum logic [2:0] {
        MODE_ABS     = 3'd0,
        MODE_REGPTR  = 3'd1,
        MODE_DISP    = 3'd2,
        MODE_IDX     = 3'd3,
        MODE_MEMIND  = 3'd4,
        MODE_STEPUP  = 3'd5,
        MODE_STEPDN  = 3'd6,
        MODE_RSVD    = 3'd7
    } eag_mode_e;
endpackage

// File: rtl/eag_addr_calc.sv
// Module: combinational address arithmetic for all single-cycle modes.
// Computes the address, the stepped base value and whether a base
// write-back is needed. All sums wrap modulo 2^AW. The memory-indirect
// address is not produced here (its address comes from memory).
module eag_addr_calc #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  eag_pkg::eag_mode_e mode,
    input  logic [AW-1:0]      base,
    input  logic [AW-1:0]      index,
    input  logic [AW-1:0]      imm,
    output logic [AW-1:0]      addr,
    output logic [AW-1:0]      new_base,
    output logic               wb_req
);
    import eag_pkg::*;

    localparam logic [AW-1:0] STEP_W = AW'(STEP);

    logic [AW-1:0] base_up;
    logic [AW-1:0] base_dn;

    // Stepped base values, wrapping in both directions.
    always_comb begin
        base_up = base + STEP_W;
        base_dn = base - STEP_W;
    end

    // Select the address and write-back value for the requested mode.
    always_comb begin
        addr     = imm;
        new_base = base;
        wb_req   = 1'b0;
        case (mode)
            MODE_ABS:    addr = imm;
            MODE_REGPTR: addr = base;
            MODE_DISP:   addr = base + imm;
            MODE_IDX:    addr = base + index;
            MODE_MEMIND: addr = base;
            MODE_STEPUP: begin
                addr     = base;
                new_base = base_up;
                wb_req   = 1'b1;
            end
            MODE_STEPDN: begin
                addr     = base_dn;
                new_base = base_dn;
                wb_req   = 1'b1;
            end
            default:     addr = imm;
        endcase
    end
endmodule

// File: rtl/eag_ind_fetch.sv
// Module: sequencer for the memory-indirect pointer read.
// On launch it latches the pointer location and holds a read request
// until the memory signals ready; done pulses combinationally in that
// cycle with the returned word on data. Assumes launch is only raised
// while busy is low.
module eag_ind_fetch #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [AW-1:0] ptr_loc,
    input  logic          mem_ready,
    input  logic [AW-1:0] mem_rdata,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          done,
    output logic [AW-1:0] data
);
    typedef enum logic { FS_IDLE = 1'b0, FS_WAIT = 1'b1 } fstate_e;

    fstate_e       state_q;
    logic [AW-1:0] loc_q;

    // State register: enter WAIT on launch, leave it when memory is ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            loc_q   <= '0;
        end else begin
            case (state_q)
                FS_IDLE: if (launch) begin
                    state_q <= FS_WAIT;
                    loc_q   <= ptr_loc;
                end
                FS_WAIT: if (mem_ready) state_q <= FS_IDLE;
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // Outputs derived from the current state.
    always_comb begin
        busy     = (state_q == FS_WAIT);
        mem_req  = busy;
        mem_addr = loc_q;
        done     = busy && mem_ready;
        data     = mem_rdata;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R6
endmodule

// File: rtl/eff_addr_gen.sv
// Module: top of the multi-mode effective address generator.
// Accepts one request per start pulse while not busy, registers the
// address (and base write-back for the stepping modes) into one-cycle
// result pulses. Memory-indirect requests go through the fetch sequencer.
// Assumes mem_rdata is valid whenever mem_ready is high during a fetch.
module eff_addr_gen #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  logic [AW-1:0] imm,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ready,
    input  logic [AW-1:0] mem_rdata,
    output logic          busy,
    output logic          ea_valid,
    output logic [AW-1:0] ea,
    output logic          wb_en,
    output logic [AW-1:0] wb_data
);
    import eag_pkg::*;

    eag_mode_e     mode_e;
    eag_mode_e     mode_q;
    logic          accept;
    logic          is_ind;
    logic [AW-1:0] calc_addr;
    logic [AW-1:0] calc_base;
    logic          calc_wb;
    logic          fetch_done;
    logic [AW-1:0] fetch_data;

    // Decode the request and decide whether it is taken this cycle.
    always_comb begin
        mode_e = eag_mode_e'(mode);
        is_ind = (mode_e == MODE_MEMIND);
        accept = start && !busy;
    end

    eag_addr_calc #(.AW(AW), .STEP(STEP)) u_calc (
        .mode     (mode_e),
        .base     (base),
        .index    (index),
        .imm      (imm),
        .addr     (calc_addr),
        .new_base (calc_base),
        .wb_req   (calc_wb)
    );

    eag_ind_fetch #(.AW(AW)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (accept && is_ind),
        .ptr_loc   (calc_addr),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .done      (fetch_done),
        .data      (fetch_data)
    );

    // Result register: one-cycle valid and write-back pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_valid <= 1'b0;
            ea       <= '0;
            wb_en    <= 1'b0;
            wb_data  <= '0;
            mode_q   <= MODE_ABS;
        end else begin
            ea_valid <= 1'b0;
            wb_en    <= 1'b0;
            if (accept) mode_q <= mode_e;
            if (fetch_done) begin
                ea_valid <= 1'b1;
                ea       <= fetch_data;
            end else if (accept && !is_ind) begin
                ea_valid <= 1'b1;
                ea       <= calc_addr;
                wb_en    <= calc_wb;
                if (calc_wb) wb_data <= calc_base;
            end
        end
    end

    AST_WB_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (ea_valid && (mode_q == MODE_STEPUP || mode_q == MODE_STEPDN))); // R10
    AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode != 3'd4) |=> ea_valid); // R12
    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ready) |=> !ea_valid); // R7
    AST_POST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid && wb_en && mode_q == MODE_STEPUP) |-> (wb_data == ea + AW'(STEP))); // R8
    AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid && wb_en && mode_q == MODE_STEPDN) |-> (wb_data == ea)); // R9
    AST_IND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (ea_valid && !wb_en && ea == $past(mem_rdata))); // R6
endmodule

// File: tb/eff_addr_gen_test.sv
// Directed bench for eff_addr_gen: one task per scenario, each checking itself.
module eff_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [31:0] base = '0, index = '0, imm = '0;
    logic        mem_req, busy, ea_valid, wb_en;
    logic [31:0] mem_addr, ea, wb_data, mem_rdata;
    logic        mem_ready = 1'b0;
    int          checks = 0;
    int          failures = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    // Bench memory: pointer word is a fixed scramble of its location.
    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
    endfunction
    assign mem_rdata = memf(mem_addr);

    eff_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .base(base), .index(index), .imm(imm),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .busy(busy), .ea_valid(ea_valid), .ea(ea),
        .wb_en(wb_en), .wb_data(wb_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue a one-cycle request; returns at the negedge after the sampling edge.
    task automatic issue(input logic [2:0] m, input logic [31:0] b,
                         input logic [31:0] x, input logic [31:0] i);
        @(negedge clk);
        start = 1'b1; mode = m; base = b; index = x; imm = i;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 ea_valid", {31'b0, ea_valid}, 32'd0);
        chk("R1 wb_en",    {31'b0, wb_en},    32'd0);
        chk("R1 mem_req",  {31'b0, mem_req},  32'd0);
        chk("R1 busy",     {31'b0, busy},     32'd0);
    endtask

    task automatic t_single(input string req, input logic [2:0] m, input logic [31:0] b,
                            input logic [31:0] x, input logic [31:0] i,
                            input logic [31:0] exp_ea, input logic exp_wb,
                            input logic [31:0] exp_wbd);
        issue(m, b, x, i);
        chk({req, " valid R12"}, {31'b0, ea_valid}, 32'd1);
        chk({req, " ea"}, ea, exp_ea);
        chk({req, " wb_en R10"}, {31'b0, wb_en}, {31'b0, exp_wb});
        if (exp_wb) chk({req, " wb_data"}, wb_data, exp_wbd);
        @(negedge clk);
        chk({req, " valid drop R12"}, {31'b0, ea_valid}, 32'd0);
        chk({req, " wb drop R10"}, {31'b0, wb_en}, 32'd0);
    endtask

    // Indirect fetch with a chosen number of wait cycles; optional stray start.
    task automatic t_memind(input logic [31:0] b, input int waits, input bit stray);
        issue(3'd4, b, 32'h1111_1111, 32'h2222_2222);
        for (int k = 0; k < waits; k++) begin
            chk("R6 mem_req", {31'b0, mem_req}, 32'd1);
            chk("R6 mem_addr", mem_addr, b);
            chk("R7 busy", {31'b0, busy}, 32'd1);
            chk("R7 no valid", {31'b0, ea_valid}, 32'd0);
            if (stray && k == 0) begin
                start = 1'b1; mode = 3'd0; imm = 32'hDEAD_BEEF;
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk("R6 mem_addr at ready", mem_addr, b);
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        chk("R6 valid", {31'b0, ea_valid}, 32'd1);
        chk("R6 ea", ea, memf(b));
        chk("R10 no wb in mode 4", {31'b0, wb_en}, 32'd0);
        chk("R6 req dropped", {31'b0, mem_req}, 32'd0);
        @(negedge clk);
        chk("R7 stray start ignored valid", {31'b0, ea_valid}, 32'd0);
        chk("R7 stray start ignored ea", ea, memf(b));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single("R2 abs",    3'd0, 32'h1234_0000, 32'h5, 32'h0000_4000, 32'h0000_4000, 1'b0, '0);
        t_single("R3 regptr", 3'd1, 32'h8000_0010, 32'h5, 32'h99,        32'h8000_0010, 1'b0, '0);
        t_single("R4 disp",   3'd2, 32'h0000_1000, 32'h5, 32'h0000_0024, 32'h0000_1024, 1'b0, '0);
        t_single("R4 disp wrap", 3'd2, 32'hFFFF_FFF0, 32'h5, 32'h0000_0020, 32'h0000_0010, 1'b0, '0);
        t_single("R5 idx",    3'd3, 32'h0000_2000, 32'h0000_0300, 32'h7, 32'h0000_2300, 1'b0, '0);
        t_single("R5 idx wrap", 3'd3, 32'hF000_0000, 32'h2000_0004, 32'h7, 32'h1000_0004, 1'b0, '0);
        t_single("R8 stepup", 3'd5, 32'h0000_0100, 32'h0, 32'h0, 32'h0000_0100, 1'b1, 32'h0000_0104);
        t_single("R8 stepup wrap", 3'd5, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'hFFFF_FFFC, 1'b1, 32'h0000_0000);
        t_single("R9 stepdn", 3'd6, 32'h0000_0100, 32'h0, 32'h0, 32'h0000_00FC, 1'b1, 32'h0000_00FC);
        t_single("R9 stepdn wrap", 3'd6, 32'h0000_0000, 32'h0, 32'h0, 32'hFFFF_FFFC, 1'b1, 32'hFFFF_FFFC);
        t_single("R11 reserved", 3'd7, 32'hAAAA_0000, 32'h1, 32'h0000_0BAD, 32'h0000_0BAD, 1'b0, '0);
        t_memind(32'h0000_4000, 0, 1'b0);
        t_memind(32'hC0DE_0008, 3, 1'b0);
        t_memind(32'h0123_4567, 2, 1'b1);
        // Back-to-back single-cycle requests: each yields its own pulse (R12).
        issue(3'd1, 32'h0000_0A00, 32'h0, 32'h0);
        chk("R12 first ea", ea, 32'h0000_0A00);
        start = 1'b1; mode = 3'd2; base = 32'h0000_0A00; imm = 32'h8;
        @(negedge clk);
        start = 1'b0;
        chk("R12 second valid", {31'b0, ea_valid}, 32'd1);
        chk("R4 second ea", ea, 32'h0000_0A08);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule